// File: doc/BRIEF.md
# Burst SRAM Control Core with Late Write and Double-Rate Lanes

This block is the synchronous control and data path of a pipelined burst static memory. On every rising clock it samples a three-wire command (a load strobe, an operation select and a length select), an address and a burst-order select. A load command starts a new four-word burst. A continue command steps the burst and repeats the operation in progress. A deselect command parks the engine. Writes are late: the data for a write arrives on the clock after its command. Reads are returned one pipeline stage after the command clock.

Double-rate traffic is carried as two words per clock. One word belongs to the rising edge and one to the falling edge, so the whole design stays in one clock domain. The storage is a behavioural array whose depth follows the address width parameter. Each output lane has its own drive flag, which stands in for the bus output enable. A lane whose flag is low shows zero data.

Top module: `ddr_burst_sram`

## Requirements
- R1: While reset is held and on the first cycle after it is released, both drive flags are low and both read-data lanes are zero.
- R2: With the load strobe `cmdLoadN` at 0, the command loads `addr` and starts a new burst at count 0. `cmdRead` selects the operation (1 read, 0 write) and `cmdSingle` selects the length (1 single, 0 double).
- R3: With `cmdLoadN`=1 and `cmdRead`=0 the command is a deselect. On the edge after the deselect edge, both drive flags fall and both read lanes read zero.
- R4: A read that becomes current at clock edge N (its load or continue was sampled at edge N) returns its data after edge N+1. That data stays for exactly one cycle unless another read follows.
- R5: A single read drives only the rising lane (`driveRise`=1, `driveFall`=0, `rdDataFall`=0). A double read drives both lanes, with burst word k on the rising lane and word k+1 on the falling lane.
- R6: A write whose command is sampled at edge N stores `wrDataRise` from edge N+1 into burst word k. A double write also stores `wrDataFall` from edge N+1 into word k+1.
- R7: With `orderInterleave`=0 at load, burst word k sits at low address bits (start + k) mod 4.
- R8: With `orderInterleave`=1 at load, burst word k sits at low address bits start XOR k.
- R9: A continue (`cmdLoadN`=1, `cmdRead`=1) after a read or write repeats that operation with the same length. It advances the burst count by 1 after a single operation and by 2 after a double, wrapping modulo 4. Address bits above bit 1 do not change.
- R10: A read of an address issued on the clock directly after a write command to that address returns the data of that write.
- R11: A continue that follows a deselect leaves the engine idle. Both lanes stay undriven and the stored data is unchanged.
- R12: The burst order is taken from `orderInterleave` at the load command. Changing that input during continues does not alter the order of the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdLoadN | input | 1 | Load strobe: 0 loads a new address |
| cmdRead | input | 1 | Operation select: 1 read, 0 write; with cmdLoadN=1 it means continue (1) or deselect (0) |
| cmdSingle | input | 1 | Length select: 1 single, 0 double |
| orderInterleave | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address loaded by a load command |
| wrDataRise | input | DATA_W | Late-write word for the rising edge |
| wrDataFall | input | DATA_W | Late-write word for the falling edge (double writes) |
| rdDataRise | output | DATA_W | Read word for the rising edge |
| rdDataFall | output | DATA_W | Read word for the falling edge |
| driveRise | output | 1 | Rising lane driven (bus not high-impedance) |
| driveFall | output | 1 | Falling lane driven |

## Verification
A command sampled at edge N becomes the current operation just after that edge. A write current at N takes its data at edge N+1. A read current at N shows its words after edge N+1, and a deselect at N clears both drive flags after edge N+1. The bench drives every command half a cycle before the edge that samples it. It then waits for that edge and checks the outputs at the next falling edge, which is one full register stage later. At that point its reference model has just retired the operation that was current before the edge.

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKindT;

  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic doRead;
    logic doWrite;
    logic isDouble;
  } stbT;

  // Low address bits of burst word `count` for a burst starting at `start`.
  function automatic logic [1:0] burstLow(input logic [1:0] start,
                                          input logic [1:0] count,
                                          input logic       interleave);
    return interleave ? (start ^ count) : (start + count);
  endfunction

endpackage

// File: rtl/ddr_burst_ctrl.sv
module ddr_burst_ctrl
  import sram_core_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdLoadN,
  input  logic              cmdRead,
  input  logic              cmdSingle,
  input  logic              orderInterleave,
  input  logic [ADDR_W-1:0] addr,
  output stbT               stb,
  output logic [ADDR_W-1:0] addrA,
  output logic [ADDR_W-1:0] addrB
);
  localparam int UP_W = ADDR_W - 2;

  opKindT          kindQ;
  logic            dblQ;
  logic            modeQ;
  logic [UP_W-1:0] upperQ;
  logic [1:0]      startQ;
  logic [1:0]      cntQ;
  logic [1:0]      stepSize;
  logic [1:0]      cntNext1;
  logic            isCont;
  logic            isDesel;

  assign isCont   = cmdLoadN && cmdRead;
  assign isDesel  = cmdLoadN && !cmdRead;
  assign stepSize = dblQ ? 2'd2 : 2'd1;
  assign cntNext1 = cntQ + 2'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ  <= OP_IDLE;
      dblQ   <= 1'b0;
      modeQ  <= 1'b0;
      upperQ <= '0;
      startQ <= 2'd0;
      cntQ   <= 2'd0;
    end else if (!cmdLoadN) begin
      kindQ  <= cmdRead ? OP_READ : OP_WRITE;
      dblQ   <= !cmdSingle;
      modeQ  <= orderInterleave;
      upperQ <= addr[ADDR_W-1:2];
      startQ <= addr[1:0];
      cntQ   <= 2'd0;
    end else if (isCont) begin
      if (kindQ != OP_IDLE) cntQ <= cntQ + stepSize;
    end else begin
      kindQ <= OP_IDLE;
    end
  end

  always_comb begin
    stb.doRead   = (kindQ == OP_READ);
    stb.doWrite  = (kindQ == OP_WRITE);
    stb.isDouble = dblQ;
    addrA = {upperQ, burstLow(startQ, cntQ, modeQ)};
    addrB = {upperQ, burstLow(startQ, cntNext1, modeQ)};
  end

  // R2: a load makes the sampled operation current on the next cycle
  a_r2_load_kind: assert property (@(posedge clk) disable iff (!rstN)
    !cmdLoadN |=> (stb.doRead == $past(cmdRead)) && (stb.doWrite == !$past(cmdRead)));

  // R2: read and write strobes are never raised together
  a_r2_one_op: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.doRead, stb.doWrite}));

  // R3: a deselect leaves no operation current
  a_r3_deselect_idle: assert property (@(posedge clk) disable iff (!rstN)
    isDesel |=> !stb.doRead && !stb.doWrite);

  // R9: a continue keeps length and upper address of the running burst
  a_r9_cont_holds: assert property (@(posedge clk) disable iff (!rstN)
    isCont |=> (stb.isDouble == $past(stb.isDouble)) &&
               (addrA[ADDR_W-1:2] == $past(addrA[ADDR_W-1:2])));

endmodule

// File: rtl/ddr_burst_data.sv
module ddr_burst_data
  import sram_core_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  stbT               stb,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] wrDataRise,
  input  logic [DATA_W-1:0] wrDataFall,
  output logic [DATA_W-1:0] rdDataRise,
  output logic [DATA_W-1:0] rdDataFall,
  output logic              driveRise,
  output logic              driveFall
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Late write: the current write operation takes the data presented now.
  always_ff @(posedge clk) begin
    if (rstN && stb.doWrite) begin
      mem[addrA] <= wrDataRise;
      if (stb.isDouble) mem[addrB] <= wrDataFall;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataRise <= '0;
      rdDataFall <= '0;
      driveRise  <= 1'b0;
      driveFall  <= 1'b0;
    end else if (stb.doRead) begin
      rdDataRise <= mem[addrA];
      rdDataFall <= stb.isDouble ? mem[addrB] : '0;
      driveRise  <= 1'b1;
      driveFall  <= stb.isDouble;
    end else begin
      rdDataRise <= '0;
      rdDataFall <= '0;
      driveRise  <= 1'b0;
      driveFall  <= 1'b0;
    end
  end

  // R5: the falling lane is only ever driven together with the rising lane
  a_r5_fall_needs_rise: assert property (@(posedge clk) disable iff (!rstN)
    driveFall |-> driveRise);

  // R4: a current read drives the bus one stage later
  a_r4_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    stb.doRead |=> driveRise);

  // R3: with no read current the next stage is undriven and zero
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !stb.doRead |=> !driveRise && !driveFall && (rdDataRise == '0) && (rdDataFall == '0));

endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram
  import sram_core_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdLoadN,
  input  logic              cmdRead,
  input  logic              cmdSingle,
  input  logic              orderInterleave,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrDataRise,
  input  logic [DATA_W-1:0] wrDataFall,
  output logic [DATA_W-1:0] rdDataRise,
  output logic [DATA_W-1:0] rdDataFall,
  output logic              driveRise,
  output logic              driveFall
);
  stbT               stb;
  logic [ADDR_W-1:0] addrA;
  logic [ADDR_W-1:0] addrB;

  ddr_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .cmdLoadN        (cmdLoadN),
    .cmdRead         (cmdRead),
    .cmdSingle       (cmdSingle),
    .orderInterleave (orderInterleave),
    .addr            (addr),
    .stb             (stb),
    .addrA           (addrA),
    .addrB           (addrB)
  );

  ddr_burst_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .addrA      (addrA),
    .addrB      (addrB),
    .wrDataRise (wrDataRise),
    .wrDataFall (wrDataFall),
    .rdDataRise (rdDataRise),
    .rdDataFall (rdDataFall),
    .driveRise  (driveRise),
    .driveFall  (driveFall)
  );

endmodule

// File: tb/ddr_burst_sram_bench.sv
module ddr_burst_sram_bench;
  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cmdLoadN, cmdRead, cmdSingle, orderInterleave;
  logic [AW-1:0] addr;
  logic [DW-1:0] wrDataRise, wrDataFall;
  logic [DW-1:0] rdDataRise, rdDataFall;
  logic          driveRise, driveFall;

  always #10 clk = ~clk;   // 50 MHz

  ddr_burst_sram #(.ADDR_W(AW), .DATA_W(DW)) u_ddr_burst_sram (
    .clk(clk), .rstN(rstN), .cmdLoadN(cmdLoadN), .cmdRead(cmdRead),
    .cmdSingle(cmdSingle), .orderInterleave(orderInterleave), .addr(addr),
    .wrDataRise(wrDataRise), .wrDataFall(wrDataFall),
    .rdDataRise(rdDataRise), .rdDataFall(rdDataFall),
    .driveRise(driveRise), .driveFall(driveFall)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string curTag = "";

  // Reference model: memory plus the operation that is current.
  logic [DW-1:0]   refMem [DEPTH];
  int              mKind = 0;       // 0 idle, 1 read, 2 write
  bit              mDbl = 0;
  bit              mMode = 0;
  logic [AW-3:0]   mUp = '0;
  logic [1:0]      mStart = 2'd0;
  logic [1:0]      mCnt = 2'd0;

  function automatic logic [1:0] seqLow(logic [1:0] s, logic [1:0] c, bit il);
    return il ? (s ^ c) : (s + c);
  endfunction

  function automatic logic [AW-1:0] modelAddr(logic [1:0] k);
    logic [1:0] c;
    c = mCnt + k;
    return {mUp, seqLow(mStart, c, mMode)};
  endfunction

  task automatic chk(string tag, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Present one command (and the late-write words) and check one stage later.
  task automatic step(bit ld, bit rd, bit sgl, logic [AW-1:0] a, bit il);
    logic [DW-1:0] wr, wf, eR, eF;
    bit            eDR, eDF;
    string         tagD, tagF;
    wr = DW'($urandom);
    wf = DW'($urandom);
    cmdLoadN = !ld; cmdRead = rd; cmdSingle = sgl; addr = a;
    orderInterleave = il; wrDataRise = wr; wrDataFall = wf;
    @(posedge clk);
    eDR = (mKind == 1);
    eDF = eDR && mDbl;
    eR  = eDR ? refMem[modelAddr(2'd0)] : '0;
    eF  = eDF ? refMem[modelAddr(2'd1)] : '0;
    if (mKind == 2) begin
      refMem[modelAddr(2'd0)] = wr;
      if (mDbl) refMem[modelAddr(2'd1)] = wf;
    end
    if (ld) begin
      mKind = rd ? 1 : 2; mDbl = !sgl; mUp = a[AW-1:2];
      mStart = a[1:0]; mCnt = 2'd0; mMode = il;
    end else if (rd) begin
      if (mKind != 0) mCnt = mCnt + (mDbl ? 2'd2 : 2'd1);
    end else begin
      mKind = 0;
    end
    @(negedge clk);
    tagD = (curTag != "") ? curTag : (eDR ? "R4" : "R3");
    tagF = (curTag != "") ? curTag : "R5";
    chk(tagD, "driveRise", DW'(driveRise), DW'(eDR));
    chk(tagF, "driveFall", DW'(driveFall), DW'(eDF));
    chk(tagD, "rdDataRise", rdDataRise, eR);
    chk(tagF, "rdDataFall", rdDataFall, eF);
  endtask

  task automatic load(bit rd, bit sgl, logic [AW-1:0] a, bit il);
    step(1'b1, rd, sgl, a, il);
  endtask
  task automatic cont(bit il = 1'b0);
    step(1'b0, 1'b1, 1'b0, '0, il);
  endtask
  task automatic desel();
    step(1'b0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog all-requirements actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    rstN = 1'b0; cmdLoadN = 1'b1; cmdRead = 1'b0; cmdSingle = 1'b1;
    orderInterleave = 1'b0; addr = '0; wrDataRise = '0; wrDataFall = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "driveRise", DW'(driveRise), '0);
    chk("R1", "driveFall", DW'(driveFall), '0);
    chk("R1", "rdDataRise", rdDataRise, '0);
    chk("R1", "rdDataFall", rdDataFall, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "driveRise after release", DW'(driveRise), '0);

    // R6: fill the whole array with double late writes and continues
    curTag = "R6";
    for (int b = 0; b < DEPTH / 4; b++) begin
      load(1'b0, 1'b0, AW'(b * 4), 1'b0);
      cont();
    end
    desel();
    // R6 / R5: read back a double burst
    load(1'b1, 1'b0, AW'(20), 1'b0); cont(); desel();

    // R7: linear single burst from start 1
    curTag = "R7";
    load(1'b1, 1'b1, AW'(9), 1'b0); cont(); cont(); cont(); cont(); desel();
    // R8: interleaved single and double bursts from start 1 and 3
    curTag = "R8";
    load(1'b1, 1'b1, AW'(9), 1'b1); cont(1'b1); cont(1'b1); cont(1'b1); desel();
    load(1'b1, 1'b0, AW'(31), 1'b1); cont(1'b1); cont(1'b1); desel();
    // R12: order fixed at load although the select toggles
    curTag = "R12";
    load(1'b1, 1'b1, AW'(14), 1'b0); cont(1'b1); cont(1'b1); cont(1'b1); desel();
    // R9: continue after double advances by two and wraps; after write repeats write
    curTag = "R9";
    load(1'b0, 1'b1, AW'(45), 1'b1); cont(); cont(); desel();
    load(1'b1, 1'b0, AW'(46), 1'b0); cont(); cont(); desel();
    // R10: read issued right after a write to the same word
    curTag = "R10";
    load(1'b0, 1'b1, AW'(33), 1'b0); load(1'b1, 1'b1, AW'(33), 1'b0); desel();
    load(1'b0, 1'b0, AW'(50), 1'b1); load(1'b1, 1'b0, AW'(51), 1'b1); desel();
    // R3: read, deselect, write ordering; bus released between
    curTag = "R3";
    load(1'b1, 1'b0, AW'(4), 1'b0); desel(); load(1'b0, 1'b0, AW'(4), 1'b0);
    load(1'b1, 1'b0, AW'(4), 1'b0); desel();
    // R11: continue after deselect does nothing; data then checked unchanged
    curTag = "R11";
    desel(); cont(); cont(); load(1'b1, 1'b0, AW'(4), 1'b0); cont(); desel();
    // R2: every load code
    curTag = "R2";
    load(1'b0, 1'b1, AW'(60), 1'b0); load(1'b0, 1'b0, AW'(61), 1'b0);
    load(1'b1, 1'b1, AW'(60), 1'b0); load(1'b1, 1'b0, AW'(60), 1'b0); desel();

    // Constrained random mix
    curTag = "";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 30)      cont(bit'($urandom_range(0, 1)));
      else if (r < 42) desel();
      else load(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                AW'($urandom_range(0, DEPTH - 1)), bit'($urandom_range(0, 1)));
    end
    desel(); desel();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule